// File: doc/BRIEF.md
# Time-of-Flight Result Calculator

This block sits behind the serial link to a time-to-digital converter and turns the raw measurement results into an interval in whole picoseconds. Upstream logic hands it the result bytes one at a time with a valid strobe. A frame is nine bytes and always has the same order: the three bytes of the coarse interval count come first, then the three bytes of the first calibration count, then the three bytes of the second calibration count. Each 24-bit word arrives with its most significant byte first.

Once the ninth byte is in, the block takes the difference of the two calibration words and divides it by the number of calibration periods less one. With the default setting of two periods, that divisor is one. The interval count is then multiplied by the reference clock period (62 500 ps for a 16 MHz reference) into a 40-bit product. A restoring divider divides that product by the calibration count, one quotient bit per clock. The truncated quotient is presented with a one-cycle done pulse. If the calibration count is not positive, the division is skipped, the result is zero and an error flag is raised. While a computation is running, busy is high and incoming bytes are dropped.

Top module: `tof_calc`

## Requirements
- R1: Bytes accepted with byte_valid high while busy is low are packed most significant byte first. Bytes 1–3 of a frame form the interval count T, bytes 4–6 form calibration word A, and bytes 7–9 form calibration word B.
- R2: The calibration count is C = (B − A) / (CAL_PERIODS − 1). The default CAL_PERIODS is 2, so C = B − A.
- R3: When B > A and C is non-zero, interval_ps = floor(T × 62 500 / C). The product is held in 40 bits, so T = 0xFFFFFF with C = 1 gives 1 048 575 937 500.
- R4: For a valid frame, done is high for exactly one cycle. It rises on the 41st rising edge after the edge that accepted the ninth byte (one setup edge plus one edge per quotient bit).
- R5: When B ≤ A, done pulses on the first edge after the ninth byte is accepted, div_err reads 1 and interval_ps reads 0.
- R6: busy is high from the edge that accepts the ninth byte until the edge that raises done. Bytes presented while busy is high do not enter the frame.
- R7: The synchronous active-low reset clears the byte index, the packed words, busy, done, div_err and interval_ps. A partly received frame is discarded.
- R8: interval_ps and div_err hold their values between done pulses. A valid result clears div_err to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_valid | input | 1 | byte_data holds a result byte |
| byte_data | input | 8 | Result byte |
| busy | output | 1 | Computation running; bytes are dropped |
| done | output | 1 | One-cycle pulse when a result is ready |
| div_err | output | 1 | Calibration count was not positive |
| interval_ps | output | 40 | Measured interval in picoseconds |

## Verification
The assertions check, on every cycle, that done never lasts longer than one cycle and that busy only falls together with done. They also check that an error result always reads zero, that the byte index stays inside the frame and that the packed words stay frozen while busy is high. Only the bench scenarios can show the arithmetic itself: byte order, the calibration difference, the truncated quotient at the 40-bit extreme, the exact latency, and that a frame cut short by reset or bytes sent while busy leave no trace in the next result.

// File: rtl/tof_calc.sv
module tof_calc #(
  parameter int BYTES_PER_WORD = 3,
  parameter int REF_PS         = 62500,
  parameter int CAL_PERIODS    = 2
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        byte_valid,
  input  logic [7:0]                                  byte_data,
  output logic                                        busy,
  output logic                                        done,
  output logic                                        div_err,
  output logic [8*BYTES_PER_WORD+$clog2(REF_PS+1)-1:0] interval_ps
);
  localparam int WORD_W  = 8 * BYTES_PER_WORD;
  localparam int REF_W   = $clog2(REF_PS + 1);
  localparam int PROD_W  = WORD_W + REF_W;
  localparam int NBYTES  = 3 * BYTES_PER_WORD;
  localparam int IDX_W   = $clog2(NBYTES);
  localparam int CNT_W   = $clog2(PROD_W);
  localparam int CAL_DIV = CAL_PERIODS - 1;

  typedef enum logic [1:0] {S_COLLECT, S_PREP, S_DIV} state_t;

  state_t              state;
  logic [IDX_W-1:0]    idx;
  logic [WORD_W-1:0]   t_word, a_word, b_word;
  logic [WORD_W-1:0]   rem;
  logic [PROD_W-1:0]   quo;
  logic [CNT_W-1:0]    cnt;

  logic [WORD_W-1:0]   cal;
  logic                cal_bad;
  logic [PROD_W-1:0]   product;
  logic [WORD_W:0]     rem_shift;
  logic                ge;
  logic [WORD_W-1:0]   rem_next;
  logic [PROD_W-1:0]   quo_next;

  assign cal       = (b_word - a_word) / WORD_W'(CAL_DIV);
  assign cal_bad   = (b_word <= a_word) || (cal == '0);
  assign product   = PROD_W'(t_word) * PROD_W'(REF_PS);
  assign rem_shift = {rem, quo[PROD_W-1]};
  assign ge        = rem_shift >= {1'b0, cal};
  assign rem_next  = ge ? WORD_W'(rem_shift - {1'b0, cal}) : rem_shift[WORD_W-1:0];
  assign quo_next  = {quo[PROD_W-2:0], ge};
  assign busy      = (state != S_COLLECT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_COLLECT;
      idx         <= '0;
      t_word      <= '0;
      a_word      <= '0;
      b_word      <= '0;
      rem         <= '0;
      quo         <= '0;
      cnt         <= '0;
      done        <= 1'b0;
      div_err     <= 1'b0;
      interval_ps <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_COLLECT: if (byte_valid) begin
          if (idx < IDX_W'(BYTES_PER_WORD))
            t_word <= {t_word[WORD_W-9:0], byte_data};
          else if (idx < IDX_W'(2*BYTES_PER_WORD))
            a_word <= {a_word[WORD_W-9:0], byte_data};
          else
            b_word <= {b_word[WORD_W-9:0], byte_data};
          if (idx == IDX_W'(NBYTES-1)) begin
            idx   <= '0;
            state <= S_PREP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_PREP: if (cal_bad) begin
          interval_ps <= '0;
          div_err     <= 1'b1;
          done        <= 1'b1;
          state       <= S_COLLECT;
        end else begin
          quo   <= product;
          rem   <= '0;
          cnt   <= '0;
          state <= S_DIV;
        end
        S_DIV: begin
          rem <= rem_next;
          quo <= quo_next;
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(PROD_W-1)) begin
            interval_ps <= quo_next;
            div_err     <= 1'b0;
            done        <= 1'b1;
            state       <= S_COLLECT;
          end
        end
        default: state <= S_COLLECT;
      endcase
    end
  end

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ends_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_frozen_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_valid) |=> ($stable(idx) && $stable(t_word) && $stable(a_word) && $stable(b_word)));

  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_err) |-> (interval_ps == '0));

  p_err_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PREP && b_word <= a_word) |=> (done && div_err));

  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IDX_W'(NBYTES));
endmodule

// File: tb/sim_tof_calc.sv
`timescale 1ns/1ps
module sim_tof_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        busy, done, div_err;
  logic [39:0] interval_ps;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  logic [39:0] exp_val_q[$];
  bit          exp_err_q[$];
  int          exp_acc_q[$];
  logic [39:0] last_val;
  bit          last_err;

  tof_calc u0 (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .busy(busy), .done(done), .div_err(div_err), .interval_ps(interval_ps)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output int acc);
    @(negedge clk);
    while (busy) @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(posedge clk);
    #1 acc = cyc;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [23:0] t, input logic [23:0] a, input logic [23:0] b);
    logic [71:0] fr;
    int acc;
    longint unsigned cal;
    fr = {t, a, b};
    for (int i = 0; i < 9; i++) send_byte(fr[71 - 8*i -: 8], acc);
    if (b <= a) begin
      exp_val_q.push_back(40'd0);
      exp_err_q.push_back(1'b1);
    end else begin
      cal = longint'(b) - longint'(a);
      exp_val_q.push_back(40'((longint'(t) * 64'd62500) / cal));
      exp_err_q.push_back(1'b0);
    end
    exp_acc_q.push_back(acc);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      logic [39:0] ev;
      bit ee;
      int ea;
      if (exp_val_q.size() == 0) begin
        check(0, "R4 unexpected done", 1, 0);
      end else begin
        ev = exp_val_q.pop_front();
        ee = exp_err_q.pop_front();
        ea = exp_acc_q.pop_front();
        check(interval_ps == ev, ee ? "R5 error result" : "R3 interval", interval_ps, ev);
        check(div_err == ee, "R5 error flag", div_err, ee);
        check((cyc - ea) == (ee ? 1 : 41), ee ? "R5 latency" : "R4 latency", cyc - ea, ee ? 1 : 41);
        last_val = ev;
        last_err = ee;
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy || exp_val_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0, "R7 busy reset", busy, 0);
    check(done == 0, "R7 done reset", done, 0);
    check(div_err == 0, "R7 err reset", div_err, 0);
    check(interval_ps == 0, "R7 interval reset", interval_ps, 0);
    rst_n = 1'b1;

    // R3 reference example, then R1 ordering with distinct bytes
    send_frame(24'd1110528, 24'd1000, 24'd1000 + 24'd289236);
    wait_idle();
    check(last_val == 40'd239970, "R3 example value", last_val, 239970);
    send_frame(24'd926720, 24'd5, 24'd5 + 24'd289237);
    send_frame(24'h123456, 24'h010203, 24'h0A0B0C);
    wait_idle();

    // R6: bytes while busy must be dropped
    begin
      logic [71:0] fr;
      int acc;
      fr = {24'd777777, 24'd100, 24'd4100};
      for (int i = 0; i < 9; i++) send_byte(fr[71 - 8*i -: 8], acc);
      exp_val_q.push_back(40'((64'd777777 * 64'd62500) / 64'd4000));
      exp_err_q.push_back(1'b0);
      exp_acc_q.push_back(acc);
      byte_valid = 1'b1;
      byte_data  = 8'hFF;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        check(busy == 1, "R6 busy during divide", busy, 1);
      end
      byte_valid = 1'b0;
    end
    send_frame(24'd50000, 24'd10, 24'd20);
    wait_idle();

    // R5 error cases, R8 hold and clear
    send_frame(24'd1234, 24'd500, 24'd500);
    wait_idle();
    repeat (10) @(negedge clk);
    check(div_err == 1, "R8 error held", div_err, 1);
    check(interval_ps == 0, "R8 zero held", interval_ps, 0);
    send_frame(24'd1234, 24'd900, 24'd800);
    send_frame(24'd9, 24'd0, 24'd3);
    wait_idle();
    repeat (10) @(negedge clk);
    check(div_err == 0, "R8 error cleared", div_err, 0);
    check(interval_ps == 40'd187500, "R8 value held", interval_ps, 187500);

    // R3 extremes and R2
    send_frame(24'hFFFFFF, 24'd0, 24'd1);
    send_frame(24'd0, 24'd7, 24'd99);
    send_frame(24'd1, 24'd0, 24'hFFFFFF);
    wait_idle();
    check(last_val == 40'd0, "R2 small quotient", last_val, 0);

    // R7 reset mid-frame discards partial bytes
    begin
      int acc;
      for (int i = 0; i < 4; i++) send_byte(8'hA5, acc);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(interval_ps == 0, "R7 interval cleared", interval_ps, 0);
      rst_n = 1'b1;
    end
    send_frame(24'd3000, 24'd100, 24'd350);
    wait_idle();
    check(last_val == 40'd750000, "R7 frame after reset", last_val, 750000);

    check(exp_val_q.size() == 0, "R4 all results seen", exp_val_q.size(), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule